// File: doc/BRIEF.md
# Adaptive Dead-Band Dual-Speed Voltage Regulator

This block closes the outer voltage loop of a power-factor-corrected rectifier. It takes a signed 8-bit output-voltage error, one sample per strobe (about 4 kHz in the target system), and produces an 8-bit control command for the downstream current-reference multiplier. The command comes from one incremental PI law. That law runs with one of two programmable coefficient pairs: a gentle pair that keeps the loop slow and blind to the twice-line ripple, and an aggressive pair that recovers quickly from load steps.

The choice between the pairs is set by a learned dead band. Each sample's error magnitude goes into a 64-deep history. The mean of that history, scaled by a programmable Q4.4 correction factor and clipped to 127, becomes the threshold. A sample whose magnitude is strictly above the threshold runs the aggressive pair, and any other sample runs the gentle pair. The comparison always uses the threshold from before the current sample was averaged in. Because the mean moves slowly, the band settles just above the steady ripple and does not follow short transients.

Top module: `dz_regulator`

## Requirements
- R1: Reset (rst_n low) sets cmd to 0, fast_mode to 0, thr to thr_init, empties the 64-entry history (all entries count as 0) and sets the stored previous error to 0.
- R2: cmd, fast_mode and thr change only in the cycle after a clock edge at which smp_valid is high. err_in is ignored at every other edge.
- R3: For each strobed sample, fast_mode becomes 1 when |err_in| (with |-128| = 128) is strictly greater than the thr value held before that sample, and 0 otherwise. Equality selects the gentle pair.
- R4: Per sample, cmd becomes cmd + floor((Ka*e - Kb*e_prev)/16). Ka and Kb are unsigned Q4.4 values taken from the fast pair when that sample's decision (R3) is 1, and from the slow pair otherwise. e_prev is the previously strobed error.
- R5: The updated cmd is clamped to the range 0 to 255.
- R6: After each sample, thr = min(127, floor(floor(S/64) * corr / 16)). S is the sum of the magnitudes of the last 64 samples, including the current one, and corr is unsigned Q4.4.
- R7: The history is a 64-sample sliding window: the 65th sample displaces the first.
- R8: All three outputs show a sample's result in the cycle right after its strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| err_in | input | 8 | Signed voltage error sample |
| slow_ka | input | 8 | Gentle pair, current-error gain (Q4.4) |
| slow_kb | input | 8 | Gentle pair, previous-error gain (Q4.4) |
| fast_ka | input | 8 | Aggressive pair, current-error gain (Q4.4) |
| fast_kb | input | 8 | Aggressive pair, previous-error gain (Q4.4) |
| corr | input | 8 | Threshold correction factor (Q4.4) |
| thr_init | input | 7 | Threshold loaded at reset |
| cmd | output | 8 | Control command |
| fast_mode | output | 1 | 1 when the last sample used the aggressive pair |
| thr | output | 7 | Current dead-band threshold |

## Verification
A corrupted history entry or running sum stays hidden until the window reaches it. It then shows up on thr, up to 64 samples later, and it can persist, because a wrong sum is never rebuilt from the history. A stale threshold or a wrong previous error shows up at once on the next sample: the first through fast_mode, the second through the cmd step. The bench therefore runs more than a full window after each change of pattern, and it checks every sample rather than only end states.

// File: rtl/dz_regulator.sv
module dz_regulator #(
  parameter int EW      = 8,
  parameter int CW      = 8,
  parameter int KW      = 8,
  parameter int FRAC    = 4,
  parameter int AVG_LOG = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [EW-1:0] err_in,
  input  logic [KW-1:0]        slow_ka,
  input  logic [KW-1:0]        slow_kb,
  input  logic [KW-1:0]        fast_ka,
  input  logic [KW-1:0]        fast_kb,
  input  logic [KW-1:0]        corr,
  input  logic [EW-2:0]        thr_init,
  output logic [CW-1:0]        cmd,
  output logic                 fast_mode,
  output logic [EW-2:0]        thr
);
  localparam int DEPTH = 1 << AVG_LOG;
  localparam int SW    = EW + AVG_LOG;
  localparam int PW    = KW + EW + 1;
  localparam int DW    = PW + 1;
  localparam int MW    = EW + KW;

  logic [EW-1:0]        hist [DEPTH];
  logic [AVG_LOG-1:0]   ptr_q;
  logic [SW-1:0]        sum_q;
  logic signed [EW-1:0] e_prev_q;
  logic [CW-1:0]        cmd_q;
  logic [EW-2:0]        thr_q;
  logic                 mode_q;

  logic [EW-1:0]        mag;
  logic                 fast_now;
  logic [KW-1:0]        ka, kb;
  logic signed [PW-1:0] prod_a, prod_b;
  logic signed [DW-1:0] diff, step;
  logic signed [DW:0]   acc;
  logic [CW-1:0]        cmd_next;
  logic [SW-1:0]        sum_next;
  logic [EW-1:0]        mean;
  logic [MW-1:0]        scaled;
  logic [EW-2:0]        thr_next;

  assign mag      = err_in[EW-1] ? (~err_in + 1'b1) : err_in;
  assign fast_now = mag > {1'b0, thr_q};
  assign ka       = fast_now ? fast_ka : slow_ka;
  assign kb       = fast_now ? fast_kb : slow_kb;
  assign prod_a   = $signed({1'b0, ka}) * err_in;
  assign prod_b   = $signed({1'b0, kb}) * e_prev_q;
  assign diff     = prod_a - prod_b;
  assign step     = diff >>> FRAC;
  assign acc      = $signed({1'b0, cmd_q}) + step;

  always_comb begin
    if (acc[DW])
      cmd_next = '0;
    else if (|acc[DW-1:CW])
      cmd_next = '1;
    else
      cmd_next = acc[CW-1:0];
  end

  assign sum_next = sum_q + SW'(mag) - SW'(hist[ptr_q]);
  assign mean     = sum_next[SW-1:AVG_LOG];
  assign scaled   = (MW'(mean) * MW'(corr)) >> FRAC;
  assign thr_next = (scaled > MW'({(EW-1){1'b1}})) ? '1 : scaled[EW-2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
      ptr_q    <= '0;
      sum_q    <= '0;
      e_prev_q <= '0;
      cmd_q    <= '0;
      thr_q    <= thr_init;
      mode_q   <= 1'b0;
    end else if (smp_valid) begin
      hist[ptr_q] <= mag;
      ptr_q    <= ptr_q + 1'b1;
      sum_q    <= sum_next;
      e_prev_q <= err_in;
      cmd_q    <= cmd_next;
      thr_q    <= thr_next;
      mode_q   <= fast_now;
    end
  end

  assign cmd       = cmd_q;
  assign fast_mode = mode_q;
  assign thr       = thr_q;
endmodule

// File: rtl/dz_regulator_chk.sv
module dz_regulator_chk #(
  parameter int EW = 8,
  parameter int CW = 8,
  parameter int KW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_valid,
  input logic signed [EW-1:0] err_in,
  input logic signed [EW-1:0] e_prev_q,
  input logic [KW-1:0]        corr,
  input logic [CW-1:0]        cmd,
  input logic                 fast_mode,
  input logic [EW-2:0]        thr
);
  logic [EW-1:0] m;
  assign m = err_in[EW-1] ? (~err_in + 1'b1) : err_in;

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(smp_valid) |-> $stable(cmd) && $stable(fast_mode) && $stable(thr));

  // R3
  mode_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(smp_valid) |-> fast_mode == ($past(m) > {1'b0, $past(thr)}));

  // R4
  zero_error_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(smp_valid) && $past(err_in) == 0 && $past(e_prev_q) == 0
    |-> cmd == $past(cmd));

  // R6
  zero_corr_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(smp_valid) && $past(corr) == 0 |-> thr == 0);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !$past(rst_n) && rst_n && !smp_valid |=> cmd == 0 && !fast_mode);
endmodule

bind dz_regulator dz_regulator_chk #(.EW(EW), .CW(CW), .KW(KW)) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .err_in(err_in),
  .e_prev_q(e_prev_q), .corr(corr), .cmd(cmd), .fast_mode(fast_mode), .thr(thr)
);

// File: tb/dz_regulator_test.sv
module dz_regulator_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [7:0] err_in = '0;
  logic [7:0] slow_ka = 8'd3, slow_kb = 8'd2, fast_ka = 8'd48, fast_kb = 8'd32;
  logic [7:0] corr = 8'h18;
  logic [6:0] thr_init = 7'd20;
  logic [7:0] cmd;
  logic fast_mode;
  logic [6:0] thr;

  always #2 clk = ~clk;

  dz_regulator uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .err_in(err_in),
    .slow_ka(slow_ka), .slow_kb(slow_kb), .fast_ka(fast_ka), .fast_kb(fast_kb),
    .corr(corr), .thr_init(thr_init), .cmd(cmd), .fast_mode(fast_mode), .thr(thr)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  string cur_tag = "R4";

  int m_hist[64];
  int m_ptr, m_sum, m_thr, m_cmd, m_ep;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_hist[i] = 0;
    m_ptr = 0; m_sum = 0; m_thr = int'(thr_init); m_cmd = 0; m_ep = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    smp_valid = 1'b0;
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  task automatic send(int e);
    int a, f, ka, kb, d, st, mean, sc;
    @(negedge clk);
    a = (e < 0) ? -e : e;
    f = (a > m_thr) ? 1 : 0;
    ka = f ? int'(fast_ka) : int'(slow_ka);
    kb = f ? int'(fast_kb) : int'(slow_kb);
    d = ka * e - kb * m_ep;
    st = d >>> 4;
    m_cmd = m_cmd + st;
    if (m_cmd < 0) m_cmd = 0;
    if (m_cmd > 255) m_cmd = 255;
    m_sum = m_sum + a - m_hist[m_ptr];
    m_hist[m_ptr] = a;
    m_ptr = (m_ptr + 1) % 64;
    mean = m_sum / 64;
    sc = (mean * int'(corr)) / 16;
    m_thr = (sc > 127) ? 127 : sc;
    m_ep = e;
    exp_q.push_back({m_cmd[7:0], f[0], m_thr[6:0]});
    tag_q.push_back(cur_tag);
    smp_valid = 1'b1;
    err_in = 8'(e);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  logic pending = 1'b0;
  always @(posedge clk) pending <= smp_valid && rst_n;

  always @(negedge clk) begin
    if (pending) begin
      logic [15:0] x;
      string t;
      if (exp_q.size() == 0) begin
        check("R8", 1, 0);
      end else begin
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " cmd"}, int'(cmd), int'(x[15:8]));
        check("R3 mode", int'(fast_mode), int'(x[7]));
        check("R6 thr", int'(thr), int'(x[6:0]));
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R1 cmd", int'(cmd), 0);
    check("R1 mode", int'(fast_mode), 0);
    check("R1 thr", int'(thr), 20);

    // R2: strobe low, error changing
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      err_in = 8'(i * 37 - 100);
    end
    @(negedge clk);
    check("R2 cmd", int'(cmd), 0);
    check("R2 thr", int'(thr), 20);

    // R3: equality with reset threshold stays slow
    cur_tag = "R3";
    send(20);
    check("R3 equal", int'(fast_mode), 0);
    send(-60);
    check("R3 above", int'(fast_mode), 1);

    // R7: fill a full window with magnitude 16
    cur_tag = "R7";
    for (int i = 0; i < 70; i++) send((i % 2) ? -16 : 16);
    check("R7 window", int'(thr), 24);
    cur_tag = "R3";
    send(24);
    check("R3 equal learned", int'(fast_mode), 0);
    send(-25);
    check("R3 exceed learned", int'(fast_mode), 1);
    send(-128);
    check("R3 min value", int'(fast_mode), 1);

    // R4: ripple pattern
    cur_tag = "R4";
    for (int i = 0; i < 80; i++) send((i % 4) * 5 - 7);

    // R5: clamping
    cur_tag = "R5";
    fast_ka = 8'd255; fast_kb = 8'd0;
    send(127);
    check("R5 upper", int'(cmd), 255);
    send(-128);
    check("R5 lower", int'(cmd), 0);

    // R6: threshold clip
    cur_tag = "R6";
    corr = 8'hFF;
    fast_ka = 8'd48; fast_kb = 8'd32;
    for (int i = 0; i < 64; i++) send(100);
    check("R6 clip", int'(thr), 127);
    corr = 8'h00;
    send(3);
    check("R6 zero corr", int'(thr), 0);

    // R1: history cleared by a second reset
    cur_tag = "R1";
    corr = 8'h10;
    thr_init = 7'd5;
    do_reset();
    @(negedge clk);
    check("R1 thr reload", int'(thr), 5);
    send(0);
    check("R1 cleared sum", int'(thr), 0);
    check("R1 cleared cmd", int'(cmd), 0);

    repeat (3) @(negedge clk);
    check("R8 queue drained", exp_q.size(), 0);
    summary();
  end
endmodule